// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block routes a wide vector of GPIO pin interrupt requests onto a smaller set of interrupt channels. Each of the 32 channels has a configuration byte that holds an enable flag and the index of one GPIO source. The chosen source is synchronised, passed through a per-channel sense detector (rising edge, falling edge, high level or low level), and any detected event is latched in a per-channel status bit. Each status bit drives an active-high level request to a parent interrupt controller.

Software reaches the configuration and status state through a simple 32-bit register port with a write strobe, a byte address and combinational read data. A handler services a channel by writing the status register with a zero in that channel's bit. Channels that are disabled never raise a request. Reprogramming a channel's source or enable re-arms its detector, so the switch itself does not look like an edge.

Each channel is run by a three-state controller. CH_OFF is the disabled state. CH_PRIME is a one-cycle state that loads the edge history from the newly selected source. CH_WATCH is the state in which events are detected. The transitions are: OFF_TO_PRIME, when a select write changes the byte and sets the enable; PRIME_TO_WATCH, on the following clock; ANY_TO_PRIME, when a changing select write keeps the enable set; and ANY_TO_OFF, when a changing select write clears the enable. A write that leaves a byte unchanged causes no transition.

Top module: `gpio_irq_selector`

## Requirements
- R1: After reset every register reads zero, every channel is in CH_OFF and all `irq_o` bits are low.
- R2: Channel c is configured by byte (c mod 4) of the select register at address 0x30 + 4*(c div 4). Bit 7 of that byte enables the channel and bits 6:0 choose the source in `gpio_irq_i`. The written value reads back.
- R3: The 2-bit sense field of channel c is at bits [2m+1:2m], with m = c mod 16. It sits in the register at 0x24 for channels 0 to 15 and at 0x28 for channels 16 to 31, and it reads back.
- R4: Sense code 0 latches status on a rising edge of the source, 1 on a falling edge, 2 while the source is high and 3 while the source is low.
- R5: Sources pass through two synchroniser flops. A source change that is an event sets the status no later than the fourth rising clock edge after the change.
- R6: A channel whose enable bit is zero never sets its status bit, whatever its source does.
- R7: A select write that changes a channel's byte puts the channel in CH_PRIME (enable set) or CH_OFF (enable clear). A difference in level between the old source and the new source then produces no event.
- R8: The status register at 0x20 reads one bit per channel. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R9: When an event and a clear reach the same status bit in the same cycle, the bit stays set.
- R10: `irq_o[c]` is an active-high level equal to status bit c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_irq_i | input | 128 | Asynchronous GPIO interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 32 | Per-channel active-high requests to the parent |

## Verification
The bench switches a channel from a low source to a high source under rising-edge sense. A design that kept its old edge history would raise a false request there. It leaves the enable clear while the source sits at the active level, which catches gating placed after the status latch. It writes the status register while a high-level source is still asserted to check that the event wins over the clear. It writes a mix of ones and zeros to the status register to catch a design that treats a written one as a set or a written zero as having no effect. Sense fields at both register boundaries (channels 15, 16 and 31) are exercised, which catches off-by-one field packing.

// File: rtl/gisel_pkg.sv
package gisel_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_PRIME = 2'd1,
        CH_WATCH = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        SENSE_RISE = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    localparam logic [7:0] ADDR_STATUS   = 8'h20;
    localparam logic [7:0] ADDR_SENSE_LO = 8'h24;
    localparam logic [7:0] ADDR_SEL_BASE = 8'h30;
    localparam int         CH_PER_SEL    = 4;
    localparam int         CH_PER_SENSE  = 16;
endpackage

// File: rtl/gisel_sync.sv
module gisel_sync #(
    parameter int WIDTH  = 128,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= async_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gisel_regs.sv
module gisel_regs
    import gisel_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int SRC_W  = 7,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_CH-1:0]            stat_i,
    output logic [NUM_CH-1:0][SRC_W-1:0] cfg_src,
    output logic [NUM_CH-1:0][1:0]       cfg_sense,
    output logic [NUM_CH-1:0]            chg,
    output logic [NUM_CH-1:0]            chg_en,
    output logic [NUM_CH-1:0]            clr
);
    localparam int SEL_REGS   = NUM_CH / CH_PER_SEL;
    localparam int SENSE_REGS = (NUM_CH + CH_PER_SENSE - 1) / CH_PER_SENSE;

    logic [SEL_REGS-1:0][31:0]   sel_q;
    logic [SENSE_REGS-1:0][31:0] sense_q;
    logic [SEL_REGS-1:0]         sel_hit;
    logic [SENSE_REGS-1:0]       sense_hit;
    logic                        stat_wr;

    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_STATUS));

    for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
        assign sel_hit[r] = bus_wr && (bus_addr == ADDR_W'(ADDR_SEL_BASE + 4 * r));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sel_q[r] <= '0;
            else if (sel_hit[r]) sel_q[r] <= bus_wdata;
        end
    end

    for (genvar r = 0; r < SENSE_REGS; r++) begin : g_sense
        assign sense_hit[r] = bus_wr && (bus_addr == ADDR_W'(ADDR_SENSE_LO + 4 * r));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sense_q[r] <= '0;
            else if (sense_hit[r]) sense_q[r] <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int RS = c / CH_PER_SEL;
        localparam int BS = c % CH_PER_SEL;
        localparam int RN = c / CH_PER_SENSE;
        localparam int FN = c % CH_PER_SENSE;
        assign cfg_src[c]   = sel_q[RS][8*BS +: SRC_W];
        assign cfg_sense[c] = sense_q[RN][2*FN +: 2];
        assign chg[c]       = sel_hit[RS] && (bus_wdata[8*BS +: 8] != sel_q[RS][8*BS +: 8]);
        assign chg_en[c]    = bus_wdata[8*BS + 7];
        assign clr[c]       = stat_wr && !bus_wdata[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_STATUS)) begin
            bus_rdata[NUM_CH-1:0] = stat_i;
        end
        for (int r = 0; r < SENSE_REGS; r++) begin
            if (bus_addr == ADDR_W'(ADDR_SENSE_LO + 4 * r)) bus_rdata = sense_q[r];
        end
        for (int r = 0; r < SEL_REGS; r++) begin
            if (bus_addr == ADDR_W'(ADDR_SEL_BASE + 4 * r)) bus_rdata = sel_q[r];
        end
    end

    // R2: a write to the first select register is held for readback
    assert_sel_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADDR_SEL_BASE)) |=> (sel_q[0] == $past(bus_wdata)));
endmodule

// File: rtl/gisel_chan.sv
module gisel_chan
    import gisel_pkg::*;
#(
    parameter int SRC_W   = 7,
    parameter int NUM_SRC = 1 << SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [1:0]         cfg_sense,
    input  logic               chg,
    input  logic               chg_en,
    input  logic               clr,
    output logic               stat_o
);
    ch_state_e state_q, state_d;
    logic      hist_q;
    logic      stat_q;
    logic      cur;
    logic      hit;
    logic      evt;

    assign cur = src_vec[cfg_src];

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   state_d = CH_OFF;
            CH_PRIME: state_d = CH_WATCH;
            CH_WATCH: state_d = CH_WATCH;
            default:  state_d = CH_OFF;
        endcase
        if (chg) state_d = chg_en ? CH_PRIME : CH_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Output process: sense detection gated by the state
    always_comb begin
        unique case (sense_e'(cfg_sense))
            SENSE_RISE: hit = cur && !hist_q;
            SENSE_FALL: hit = !cur && hist_q;
            SENSE_HIGH: hit = cur;
            SENSE_LOW:  hit = !cur;
            default:    hit = 1'b0;
        endcase
        evt = (state_q == CH_WATCH) && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            hist_q <= cur;
            stat_q <= evt || (stat_q && !clr);
        end
    end

    assign stat_o = stat_q;

    // R6: status only rises out of the watching state
    assert_off_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> ($past(state_q) == CH_WATCH));
    // R7: a configuration change always re-arms before detecting
    assert_chg_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (state_q != CH_WATCH));
    // R8: a clear without a competing event drops the bit
    assert_clr_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !stat_q);
    // R9: an event always leaves the bit set, even against a clear
    assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> stat_q);
endmodule

// File: rtl/gpio_irq_selector.sv
module gpio_irq_selector
    import gisel_pkg::*;
#(
    parameter int NUM_CH      = 32,
    parameter int SRC_W       = 7,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SRC_W)-1:0] gpio_irq_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [31:0]           bus_wdata_i,
    output logic [31:0]           bus_rdata_o,
    output logic [NUM_CH-1:0]     irq_o
);
    localparam int NUM_SRC = 1 << SRC_W;

    logic [NUM_SRC-1:0]            src_sync;
    logic [NUM_CH-1:0][SRC_W-1:0]  cfg_src;
    logic [NUM_CH-1:0][1:0]        cfg_sense;
    logic [NUM_CH-1:0]             chg;
    logic [NUM_CH-1:0]             chg_en;
    logic [NUM_CH-1:0]             clr;
    logic [NUM_CH-1:0]             stat;

    gisel_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (gpio_irq_i),
        .sync_o  (src_sync)
    );

    gisel_regs #(.NUM_CH(NUM_CH), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr_i),
        .bus_addr  (bus_addr_i),
        .bus_wdata (bus_wdata_i),
        .bus_rdata (bus_rdata_o),
        .stat_i    (stat),
        .cfg_src   (cfg_src),
        .cfg_sense (cfg_sense),
        .chg       (chg),
        .chg_en    (chg_en),
        .clr       (clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        gisel_chan #(.SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_vec   (src_sync),
            .cfg_src   (cfg_src[c]),
            .cfg_sense (cfg_sense[c]),
            .chg       (chg[c]),
            .chg_en    (chg_en[c]),
            .clr       (clr[c]),
            .stat_o    (stat[c])
        );
    end

    assign irq_o = stat;
endmodule

// File: tb/test_gpio_irq_selector.sv
module test_gpio_irq_selector;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] gpio = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_selector i_gpio_irq_selector (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpio_irq_i  (gpio),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // vector: [16:12] channel, [11:5] source, [4:3] sense, [2] start level, [1] end level, [0] expected irq
    localparam int NVEC = 10;
    localparam logic [16:0] VEC [NVEC] = '{
        {5'd0,  7'd5,   2'd0, 1'b0, 1'b1, 1'b1},
        {5'd0,  7'd5,   2'd0, 1'b1, 1'b0, 1'b0},
        {5'd7,  7'd100, 2'd1, 1'b1, 1'b0, 1'b1},
        {5'd7,  7'd100, 2'd1, 1'b0, 1'b1, 1'b0},
        {5'd16, 7'd127, 2'd2, 1'b0, 1'b1, 1'b1},
        {5'd16, 7'd127, 2'd2, 1'b0, 1'b0, 1'b0},
        {5'd31, 7'd0,   2'd3, 1'b1, 1'b0, 1'b1},
        {5'd31, 7'd0,   2'd3, 1'b1, 1'b1, 1'b0},
        {5'd20, 7'd64,  2'd0, 1'b0, 1'b1, 1'b1},
        {5'd15, 7'd33,  2'd3, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sel_addr(input int c);
        return 8'h30 + 8'(4 * (c / 4));
    endfunction

    function automatic logic [31:0] sel_data(input int c, input logic en, input logic [6:0] s);
        return {24'd0, en, s} << (8 * (c % 4));
    endfunction

    function automatic logic [7:0] sense_addr(input int c);
        return (c < 16) ? 8'h24 : 8'h28;
    endfunction

    function automatic logic [31:0] sense_data(input int c, input logic [1:0] s);
        return {30'd0, s} << (2 * (c % 16));
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq after reset", irq, 32'h0);
        rd(8'h20, r); chk("R1 status after reset", r, 32'h0);
        rd(8'h3C, r); chk("R1 select after reset", r, 32'h0);
        rd(8'h28, r); chk("R1 sense after reset", r, 32'h0);

        // R2 / R3: readback and field placement
        wr(8'h34, 32'h8A00_0000);
        rd(8'h34, r); chk("R2 select readback", r, 32'h8A00_0000);
        wr(8'h34, 32'h0);
        wr(8'h28, 32'hC000_0001);
        rd(8'h28, r); chk("R3 sense readback high reg", r, 32'hC000_0001);
        rd(8'h24, r); chk("R3 sense low reg untouched", r, 32'h0);
        wr(8'h28, 32'h0);

        // Vector table: R4 sense codes, R5 latency, R10 output
        for (int i = 0; i < NVEC; i++) begin
            int          c;
            logic [6:0]  s;
            logic [1:0]  sn;
            c  = int'(VEC[i][16:12]);
            s  = VEC[i][11:5];
            sn = VEC[i][4:3];
            gpio[s] = VEC[i][2];
            wr(sense_addr(c), sense_data(c, sn));
            wr(sel_addr(c), sel_data(c, 1'b1, s));
            wait_cyc(6);
            wr(8'h20, 32'h0);
            gpio[s] = VEC[i][1];
            wait_cyc(6);
            chk($sformatf("R4 R5 R10 vector %0d", i), 32'(irq[c]), 32'(VEC[i][0]));
            wr(sel_addr(c), 32'h0);
            wr(sense_addr(c), 32'h0);
            wr(8'h20, 32'h0);
            gpio = '0;
            wait_cyc(4);
        end

        // R6: disabled channel with an active high-level source
        gpio[20] = 1'b1;
        wr(8'h24, sense_data(5, 2'd2));
        wr(sel_addr(5), sel_data(5, 1'b0, 7'd20));
        wait_cyc(8);
        chk("R6 disabled channel stays quiet", irq, 32'h0);
        rd(8'h20, r); chk("R6 disabled status", r, 32'h0);
        wr(sel_addr(5), 32'h0); wr(8'h24, 32'h0); gpio = '0;

        // R7: switching to a high source must not look like a rising edge
        gpio[11] = 1'b1;
        wr(sel_addr(3), sel_data(3, 1'b1, 7'd10));
        wait_cyc(6);
        wr(8'h20, 32'h0);
        wr(sel_addr(3), sel_data(3, 1'b1, 7'd11));
        wait_cyc(8);
        chk("R7 source switch no false edge", 32'(irq[3]), 32'h0);
        gpio[11] = 1'b0; wait_cyc(6);
        gpio[11] = 1'b1; wait_cyc(6);
        chk("R7 real edge after switch", 32'(irq[3]), 32'h1);
        wr(sel_addr(3), 32'h0); wr(8'h20, 32'h0); gpio = '0;

        // R8: write-zero clears, write-one keeps
        wr(8'h30, sel_data(0, 1'b1, 7'd5) | sel_data(1, 1'b1, 7'd6));
        wait_cyc(4);
        gpio[5] = 1'b1; gpio[6] = 1'b1;
        wait_cyc(6);
        rd(8'h20, r); chk("R8 both set", r, 32'h3);
        wr(8'h20, 32'hFFFF_FFFE);
        rd(8'h20, r); chk("R8 only zero bit cleared", r, 32'h2);
        chk("R10 irq matches status", irq, 32'h2);
        wr(8'h30, 32'h0); wr(8'h20, 32'h0); gpio = '0;

        // R9: clear against a persisting high level
        gpio[127] = 1'b1;
        wr(8'h28, sense_data(16, 2'd2));
        wr(sel_addr(16), sel_data(16, 1'b1, 7'd127));
        wait_cyc(6);
        wr(8'h20, 32'h0);
        rd(8'h20, r); chk("R9 event beats clear", r, 32'h0001_0000);
        gpio[127] = 1'b0; wait_cyc(4);
        wr(8'h20, 32'h0);
        rd(8'h20, r); chk("R8 cleared once level gone", r, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule